// File: doc/BRIEF.md
# NAND Page Copy-Back Sequencer

This block moves one page of a NAND flash device to another page entirely inside the device, without any data passing through the host. The host hands it a source page address, a target page address and a density code over a valid/ready request channel. The block then runs the two device phases. The first phase reads the source page into the device page buffer. The second phase programs that buffer into the target page. After the second phase the block reads the device status byte and reports the result. The host does no more than issue the request and then read the result.

A source and target pair is only legal when both addresses agree in one address bit, and the density code selects that bit. The block checks this before it touches the flash bus and turns away an illegal pair at once. A page that has been the target of a copy-back must not then receive a partial-page program until its block is erased. The block therefore keeps a small table of locked target pages. It answers lookups against that table and clears entries when the host reports a block erase.

On the request channel, a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while an operation runs and while the lock table is full. A held `req_valid` simply waits, and the request fields must stay steady while it waits. The result pins are plain levels. They are valid from `done` until the next request is accepted.

Top module: `nand_cpbk_seq`

## Requirements
- R1: An accepted legal request first writes command byte 00h with `nf_cle` high, then ADDR_BYTES address bytes of the source page, lowest byte first, each with `nf_ale` high. Every byte is marked by exactly one cycle of `nf_we_n` low, and the bus is driven during that cycle.
- R2: The second phase starts only after `nf_rb_n` is sampled high, at least WB_CYC cycles after the last source address byte. It writes command 8Ah, then the target address bytes lowest first, then confirm byte 10h.
- R3: When the program busy period ends, the block writes command 70h and then pulses `nf_re_n` low for exactly one cycle. It captures `nf_io_in` into `status`, and `fail` equals bit 0 of that byte.
- R4: The checked bit is address bit BASE_BIT+`req_dens` for density codes 0, 1 and 2. Code 3 is reserved. If the checked bits of source and target differ, or the code is 3, the request is rejected: `addr_err` and `done` rise, and no bus strobe occurs.
- R5: If `nf_rb_n` stays low for TMO_CYC consecutive cycles in either ready wait, the operation stops. `timeout` and `done` rise, no further bus byte is written, and no page is locked.
- R6: `req_ready` is high only while the block is idle and the lock table has room. `busy` is high from acceptance until `done`. `done`, `status`, `fail`, `addr_err` and `timeout` hold steady until the next acceptance.
- R7: Each copy-back that reaches the status read locks its target page. After that, `pp_locked` is high whenever `pp_query` equals that page.
- R8: An `erase_en` pulse clears every lock whose page matches `erase_page` in the address bits at and above BLK_SHIFT. Locks in other blocks are kept.
- R9: With LOCK_DEPTH pages locked, `req_ready` stays low and a waiting request produces no bus activity.
- R10: `nf_cle` and `nf_ale` are never high together. `nf_we_n` and `nf_re_n` are never low together. While `nf_ce_n` is high, both strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_src | input | 8*ADDR_BYTES | Source page address |
| req_dst | input | 8*ADDR_BYTES | Target page address |
| req_dens | input | 2 | Density code selecting the checked bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid |
| fail | output | 1 | Status bit 0 of the finished operation |
| addr_err | output | 1 | Request rejected by the address check |
| timeout | output | 1 | Ready wait exceeded its limit |
| status | output | 8 | Captured device status byte |
| pp_query | input | 8*ADDR_BYTES | Page to look up in the lock table |
| pp_locked | output | 1 | Queried page is locked |
| erase_en | input | 1 | Host reports a block erase |
| erase_page | input | 8*ADDR_BYTES | Any page inside the erased block |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_io_out | output | 8 | Byte driven onto the flash I/O bus |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Byte read from the flash I/O bus |
| nf_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
The hardest conditions to reach from the ports are a ready line that never returns and a lock table that has filled up. The bench's device model can hold ready/busy low without end on either its first or its second busy period, so it can drive both timeout exits and then count how many bytes reached the bus. To fill the table, a run of legal copy-backs targets pages in distinct blocks, with no erase between them. A further request is then held waiting against the low ready, and the bench confirms that it stays parked. After that, one block is erased to free a single entry. Every density code is swept against all four agree and disagree combinations of the checked bit.

// File: rtl/nand_cpbk_pkg.sv
package nand_cpbk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_WB, ST_RB, ST_RD, ST_FIN
  } cpbk_st_e;

  localparam logic [7:0] OP_SRC_RD = 8'h00;
  localparam logic [7:0] OP_MOVE   = 8'h8A;
  localparam logic [7:0] OP_GO     = 8'h10;
  localparam logic [7:0] OP_STAT   = 8'h70;
endpackage

// File: rtl/nand_cpbk_addr_chk.sv
module nand_cpbk_addr_chk #(
  parameter int DENS_N = 3,
  parameter int DENS_W = 2
) (
  input  logic [DENS_N-1:0] diff,
  input  logic [DENS_W-1:0] dens,
  output logic              ok
);
  always_comb begin
    ok = 1'b0;
    for (int d = 0; d < DENS_N; d++) begin
      if (dens == DENS_W'(d)) ok = ~diff[d];
    end
  end
endmodule

// File: rtl/nand_cpbk_lock.sv
module nand_cpbk_lock #(
  parameter int ADDR_W    = 32,
  parameter int DEPTH     = 8,
  parameter int BLK_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_page,
  input  logic              ers_en,
  input  logic [ADDR_W-1:0] ers_page,
  input  logic [ADDR_W-1:0] q_page,
  output logic              q_hit,
  output logic              full
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_SHIFT) - ADDR_W'(1));

  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  hit_v, ers_v, dup_v, sel;
  logic [ADDR_W-1:0] pg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign hit_v[i] = vld[i] && (pg[i] == q_page);
    assign dup_v[i] = vld[i] && (pg[i] == ins_page);
    assign ers_v[i] = ers_en && vld[i] && (((pg[i] ^ ers_page) & BLK_MASK) == '0);

    always_ff @(posedge clk) begin
      if (ins_en && sel[i]) pg[i] <= ins_page;
    end
  end

  always_comb begin
    sel = '0;
    if (!(|dup_v)) begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (!vld[i]) sel = DEPTH'(1) << i;
      end
    end
  end

  assign q_hit = |hit_v;
  assign full  = &vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= (vld & ~ers_v) | (ins_en ? sel : '0);
  end
endmodule

// File: rtl/nand_cpbk_fsm.sv
module nand_cpbk_fsm
  import nand_cpbk_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int WB_CYC     = 2,
  parameter int TMO_CYC    = 100000,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              addr_ok,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              idle,
  output logic              done,
  output logic              fail,
  output logic              addr_err,
  output logic              timeout,
  output logic [7:0]        status,
  output logic              lock_ins,
  output logic [ADDR_W-1:0] lock_page,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_io_out,
  output logic              nf_io_oe,
  input  logic [7:0]        nf_io_in,
  input  logic              nf_rb_n
);
  localparam int N        = ADDR_BYTES;
  localparam int IDX_LAST = 2 * N + 3;
  localparam int IW       = $clog2(IDX_LAST + 1);
  localparam int WW       = $clog2(WB_CYC + 1);
  localparam int TW       = $clog2(TMO_CYC + 1);
  localparam logic [IW-1:0] I_SRC_END = IW'(N);
  localparam logic [IW-1:0] I_MOVE    = IW'(N + 1);
  localparam logic [IW-1:0] I_GO      = IW'(2 * N + 2);
  localparam logic [IW-1:0] I_STAT    = IW'(2 * N + 3);

  cpbk_st_e          st;
  logic [IW-1:0]     idx;
  logic              ph;
  logic [WW-1:0]     wcnt;
  logic [TW-1:0]     tcnt;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [7:0]        cur_byte;
  logic              cur_cmd;

  always_comb begin
    cur_byte = OP_SRC_RD;
    cur_cmd  = 1'b1;
    if (idx == I_MOVE) cur_byte = OP_MOVE;
    if (idx == I_GO)   cur_byte = OP_GO;
    if (idx == I_STAT) cur_byte = OP_STAT;
    for (int k = 0; k < N; k++) begin
      if (idx == IW'(k + 1)) begin
        cur_byte = src_q[8*k +: 8];
        cur_cmd  = 1'b0;
      end
      if (idx == IW'(N + 2 + k)) begin
        cur_byte = dst_q[8*k +: 8];
        cur_cmd  = 1'b0;
      end
    end
  end

  assign idle      = (st == ST_IDLE);
  assign nf_ce_n   = (st == ST_IDLE) || (st == ST_FIN);
  assign nf_io_oe  = (st == ST_WR);
  assign nf_cle    = (st == ST_WR) && cur_cmd;
  assign nf_ale    = (st == ST_WR) && !cur_cmd;
  assign nf_we_n   = !((st == ST_WR) && !ph);
  assign nf_re_n   = !(st == ST_RD);
  assign nf_io_out = (st == ST_WR) ? cur_byte : 8'h00;
  assign lock_ins  = (st == ST_RD);
  assign lock_page = dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      ph       <= 1'b0;
      wcnt     <= '0;
      tcnt     <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      addr_err <= 1'b0;
      timeout  <= 1'b0;
      status   <= 8'h00;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          src_q    <= src;
          dst_q    <= dst;
          done     <= 1'b0;
          fail     <= 1'b0;
          timeout  <= 1'b0;
          status   <= 8'h00;
          idx      <= '0;
          ph       <= 1'b0;
          addr_err <= !addr_ok;
          st       <= addr_ok ? ST_WR : ST_FIN;
        end
        ST_WR: begin
          ph <= !ph;
          if (ph) begin
            if (idx == I_SRC_END || idx == I_GO) begin
              wcnt <= '0;
              st   <= ST_WB;
            end else if (idx == I_STAT) begin
              st <= ST_RD;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        end
        ST_WB: begin
          wcnt <= wcnt + WW'(1);
          if (wcnt == WW'(WB_CYC - 1)) begin
            tcnt <= '0;
            st   <= ST_RB;
          end
        end
        ST_RB: begin
          if (nf_rb_n) begin
            idx <= idx + IW'(1);
            st  <= ST_WR;
          end else if (tcnt == TW'(TMO_CYC - 1)) begin
            timeout <= 1'b1;
            st      <= ST_FIN;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_RD: begin
          status <= nf_io_in;
          fail   <= nf_io_in[0];
          st     <= ST_FIN;
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cpbk_seq.sv
module nand_cpbk_seq #(
  parameter int ADDR_BYTES = 4,
  parameter int BASE_BIT   = 23,
  parameter int WB_CYC     = 2,
  parameter int TMO_CYC    = 100000,
  parameter int LOCK_DEPTH = 8,
  parameter int BLK_SHIFT  = 5,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [1:0]        req_dens,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              addr_err,
  output logic              timeout,
  output logic [7:0]        status,
  input  logic [ADDR_W-1:0] pp_query,
  output logic              pp_locked,
  input  logic              erase_en,
  input  logic [ADDR_W-1:0] erase_page,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_io_out,
  output logic              nf_io_oe,
  input  logic [7:0]        nf_io_in,
  input  logic              nf_rb_n
);
  localparam int DENS_N = 3;

  logic              idle, full, addr_ok, start, lock_ins;
  logic [ADDR_W-1:0] lock_page;
  logic [DENS_N-1:0] diff;

  assign diff      = req_src[BASE_BIT +: DENS_N] ^ req_dst[BASE_BIT +: DENS_N];
  assign req_ready = idle && !full;
  assign start     = req_valid && req_ready;
  assign busy      = !idle;

  nand_cpbk_addr_chk #(.DENS_N(DENS_N), .DENS_W(2)) i_chk_addr (
    .diff (diff),
    .dens (req_dens),
    .ok   (addr_ok)
  );

  nand_cpbk_lock #(.ADDR_W(ADDR_W), .DEPTH(LOCK_DEPTH), .BLK_SHIFT(BLK_SHIFT)) i_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (lock_ins),
    .ins_page (lock_page),
    .ers_en   (erase_en),
    .ers_page (erase_page),
    .q_page   (pp_query),
    .q_hit    (pp_locked),
    .full     (full)
  );

  nand_cpbk_fsm #(.ADDR_BYTES(ADDR_BYTES), .WB_CYC(WB_CYC), .TMO_CYC(TMO_CYC)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .addr_ok   (addr_ok),
    .src       (req_src),
    .dst       (req_dst),
    .idle      (idle),
    .done      (done),
    .fail      (fail),
    .addr_err  (addr_err),
    .timeout   (timeout),
    .status    (status),
    .lock_ins  (lock_ins),
    .lock_page (lock_page),
    .nf_ce_n   (nf_ce_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_io_out (nf_io_out),
    .nf_io_oe  (nf_io_oe),
    .nf_io_in  (nf_io_in),
    .nf_rb_n   (nf_rb_n)
  );
endmodule

// File: rtl/nand_cpbk_chk.sv
module nand_cpbk_chk #(
  parameter int ADDR_W   = 32,
  parameter int BASE_BIT = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_src,
  input logic [ADDR_W-1:0] req_dst,
  input logic [1:0]        req_dens,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              addr_err,
  input logic [7:0]        status,
  input logic              nf_ce_n,
  input logic              nf_cle,
  input logic              nf_ale,
  input logic              nf_we_n,
  input logic              nf_re_n,
  input logic              nf_io_oe
);
  logic acc, bad_pair;
  assign acc = req_valid && req_ready;
  always_comb begin
    case (req_dens)
      2'd0:    bad_pair = req_src[BASE_BIT]     != req_dst[BASE_BIT];
      2'd1:    bad_pair = req_src[BASE_BIT + 1] != req_dst[BASE_BIT + 1];
      2'd2:    bad_pair = req_src[BASE_BIT + 2] != req_dst[BASE_BIT + 2];
      default: bad_pair = 1'b1;
    endcase
  end

  p_cle_ale_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  p_we_re_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  p_ce_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nf_ce_n |-> (nf_we_n && nf_re_n));
  p_we_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> (nf_io_oe && (nf_cle || nf_ale)));
  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad_pair) |=> (nf_ce_n && nf_we_n));
  p_reject_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad_pair) |-> ##2 (done && addr_err));
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> (done && $stable(status) && $stable(fail) && $stable(addr_err)));
  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
endmodule

bind nand_cpbk_seq nand_cpbk_chk #(.ADDR_W(ADDR_W), .BASE_BIT(BASE_BIT)) i_cpbk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_src   (req_src),
  .req_dst   (req_dst),
  .req_dens  (req_dens),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .addr_err  (addr_err),
  .status    (status),
  .nf_ce_n   (nf_ce_n),
  .nf_cle    (nf_cle),
  .nf_ale    (nf_ale),
  .nf_we_n   (nf_we_n),
  .nf_re_n   (nf_re_n),
  .nf_io_oe  (nf_io_oe)
);

// File: tb/test_nand_cpbk_seq.sv
`timescale 1ns/1ps
module test_nand_cpbk_seq;
  localparam int AB = 4;
  localparam int AW = 8 * AB;
  localparam int BB = 23;
  localparam int TMO = 40;
  localparam int DEP = 4;
  localparam int BS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic [1:0] req_dens = 2'd0;
  logic busy, done, fail, addr_err, timeout, pp_locked;
  logic [7:0] status;
  logic [AW-1:0] pp_query = '0, erase_page = '0;
  logic erase_en = 1'b0;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [7:0] nf_io_out;
  logic [7:0] nf_io_in = 8'h00;
  logic nf_rb_n = 1'b1;

  always #4 clk = ~clk;

  nand_cpbk_seq #(.ADDR_BYTES(AB), .BASE_BIT(BB), .WB_CYC(2), .TMO_CYC(TMO),
                  .LOCK_DEPTH(DEP), .BLK_SHIFT(BS)) i_nand_cpbk_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_dens(req_dens), .busy(busy),
    .done(done), .fail(fail), .addr_err(addr_err), .timeout(timeout),
    .status(status), .pp_query(pp_query), .pp_locked(pp_locked),
    .erase_en(erase_en), .erase_page(erase_page), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
    .nf_rb_n(nf_rb_n));

  int total = 0, bad = 0, cyc = 0;
  int n_log = 0, n_rd = 0, acnt = 0, bnum = 0, bsy_cnt = 0, blen = 12, stall_sel = 0;
  bit early_move = 0;
  logic [7:0] last_cmd = 8'hFF;
  logic [9:0] lg [32];

  // device model: logs writes, raises busy after the source address and after confirm
  always @(negedge clk) begin
    if (!nf_we_n) begin
      if (n_log < 32) lg[n_log] = {nf_cle, nf_ale, nf_io_out};
      n_log++;
      if (nf_cle) begin
        last_cmd = nf_io_out;
        acnt = 0;
        if (nf_io_out == 8'h8A && bsy_cnt != 0) early_move = 1;
        if (nf_io_out == 8'h10) begin
          bnum++;
          bsy_cnt = (stall_sel == bnum) ? 1000000 : blen;
        end
      end else if (nf_ale) begin
        acnt++;
        if (last_cmd == 8'h00 && acnt == AB) begin
          bnum++;
          bsy_cnt = (stall_sel == bnum) ? 1000000 : blen;
        end
      end
    end else if (bsy_cnt > 0) bsy_cnt--;
    if (!nf_re_n) n_rd++;
    nf_rb_n = (bsy_cnt == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic query(input logic [AW-1:0] p, input logic exp, input string req);
    pp_query = p;
    #1;
    check(req, {31'd0, pp_locked}, {31'd0, exp});
  endtask

  task automatic erase(input logic [AW-1:0] p);
    @(negedge clk);
    erase_en = 1'b1;
    erase_page = p;
    @(negedge clk);
    erase_en = 1'b0;
  endtask

  task automatic run_op(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [1:0] dn,
                        input logic [7:0] st, input int stall);
    @(negedge clk);
    n_log = 0; n_rd = 0; bnum = 0; bsy_cnt = 0; early_move = 0;
    stall_sel = stall;
    nf_io_in = st;
    req_src = s; req_dst = d; req_dens = dn;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 busy after accept", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    check("R6 done", {31'd0, done}, 32'd1);
    check("R10 ce released", {31'd0, nf_ce_n}, 32'd1);
  endtask

  task automatic expect_legal(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [7:0] st);
    check("R1 R2 R3 byte count", n_log, 2 * AB + 4);
    check("R1 cmd 00", {22'd0, lg[0]}, {22'd0, 2'b10, 8'h00});
    for (int j = 0; j < AB; j++) begin
      check("R1 src addr byte", {22'd0, lg[1 + j]}, {22'd0, 2'b01, s[8*j +: 8]});
      check("R2 dst addr byte", {22'd0, lg[AB + 2 + j]}, {22'd0, 2'b01, d[8*j +: 8]});
    end
    check("R2 cmd 8A", {22'd0, lg[AB + 1]}, {22'd0, 2'b10, 8'h8A});
    check("R2 confirm 10", {22'd0, lg[2 * AB + 2]}, {22'd0, 2'b10, 8'h10});
    check("R3 cmd 70", {22'd0, lg[2 * AB + 3]}, {22'd0, 2'b10, 8'h70});
    check("R2 move waits for ready", {31'd0, early_move}, 32'd0);
    check("R3 one read strobe", n_rd, 1);
    check("R3 status", {24'd0, status}, {24'd0, st});
    check("R3 fail bit", {31'd0, fail}, {31'd0, st[0]});
    check("R4 no addr_err", {31'd0, addr_err}, 32'd0);
    check("R5 no timeout", {31'd0, timeout}, 32'd0);
  endtask

  initial begin
    logic [AW-1:0] s, d, b1, b2;
    logic [7:0] st;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset ready", {31'd0, req_ready}, 32'd1);
    check("R6 reset busy", {31'd0, busy}, 32'd0);
    check("R6 reset done", {31'd0, done}, 32'd0);
    check("R10 reset ce", {31'd0, nf_ce_n}, 32'd1);
    check("R10 reset we", {31'd0, nf_we_n}, 32'd1);
    query(32'h0, 1'b0, "R7 reset lock");

    // sweep: every density code against every combination of the checked bit
    for (int dn = 0; dn < 4; dn++) begin
      for (int p = 0; p < 4; p++) begin
        int k = dn * 4 + p;
        s = 32'h0000_0113 + 32'h0101_0120 * k;
        d = s ^ 32'h0005_5A60;
        if (dn < 3) begin
          s[BB + dn] = p[0];
          d[BB + dn] = p[1];
        end
        st = 8'hC0 | 8'(k);
        ok = (dn < 3) && (p[0] == p[1]);
        blen = 6 + 2 * k;
        run_op(s, d, 2'(dn), st, 0);
        if (ok) begin
          expect_legal(s, d, st);
          repeat (5) @(negedge clk);
          check("R6 done holds", {31'd0, done}, 32'd1);
          check("R6 status holds", {24'd0, status}, {24'd0, st});
          query(d, 1'b1, "R7 target locked");
          query(s, 1'b0, "R7 source not locked");
          erase(d ^ 32'h0000_001F);
          query(d, 1'b0, "R8 erase clears lock");
        end else begin
          check("R4 reject no bytes", n_log, 0);
          check("R4 reject no read", n_rd, 0);
          check("R4 addr_err", {31'd0, addr_err}, 32'd1);
          check("R4 reject no fail", {31'd0, fail}, 32'd0);
          query(d, 1'b0, "R4 reject no lock");
        end
      end
    end

    // timeout in the first busy wait
    blen = 6;
    s = 32'h0000_2200; d = 32'h0000_3300;
    run_op(s, d, 2'd0, 8'hC0, 1);
    check("R5 timeout first wait", {31'd0, timeout}, 32'd1);
    check("R5 bytes before stop", n_log, AB + 1);
    check("R5 no read", n_rd, 0);
    query(d, 1'b0, "R5 no lock after timeout");
    bsy_cnt = 0;
    // timeout in the program wait
    run_op(s, d, 2'd0, 8'hC0, 2);
    check("R5 timeout second wait", {31'd0, timeout}, 32'd1);
    check("R5 bytes before stop 2", n_log, 2 * AB + 3);
    query(d, 1'b0, "R5 no lock after timeout 2");
    bsy_cnt = 0;

    // fill the lock table
    for (int b = 1; b <= DEP; b++) begin
      d = (32'(b) << BS) | 32'h3;
      run_op(32'h0000_0400 + 32'(b), d, 2'd0, 8'hC0, 0);
      query(d, 1'b1, "R7 fill lock");
    end
    @(negedge clk);
    check("R9 full ready low", {31'd0, req_ready}, 32'd0);
    n_log = 0;
    req_src = 32'h0000_0777; req_dst = 32'h0000_0E01; req_dens = 2'd0;
    req_valid = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 parked not busy", {31'd0, busy}, 32'd0);
    check("R9 parked no bytes", n_log, 0);
    req_valid = 1'b0;
    b1 = (32'd1 << BS) | 32'h3;
    b2 = (32'd2 << BS) | 32'h3;
    erase(b2 ^ 32'h4);
    query(b2, 1'b0, "R8 erased block cleared");
    query(b1, 1'b1, "R8 other block kept");
    @(negedge clk);
    check("R9 ready after erase", {31'd0, req_ready}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule